// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Flag Unit

This block computes the byte result, the updated accumulator and the new eight-bit flag byte for the rotate, shift and bit-test group of an 8-bit processor's instruction set. The decode stage supplies an operation code, the operand byte, the current accumulator, a bit index and the incoming flag byte. The unit returns all three outputs one clock later. Memory access and write-back belong to the surrounding datapath.

The group has four kinds of operation. The fast accumulator rotates work on A only and leave the sign, zero and parity flags untouched. The general rotates and shifts work on the operand, and this set includes a nonstandard left shift that fills bit 0 with a one. The nibble rotates move 12 bits around A's low nibble and the two nibbles of the operand. The bit test examines one bit of the operand.

Top module: `rsb_unit`

## Requirements
- R1: Outputs are registered with one cycle of latency: the values driven on the inputs before a rising clock edge appear on `res_out`, `acc_out` and `flags_out` after that edge. A synchronous active-high `rst` clears all three outputs to zero.
- R2: The flag byte layout is fixed: bit 7 sign, bit 6 zero, bit 5 copy-5, bit 4 half-carry, bit 3 copy-3, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Parity is 1 when the byte has an even number of ones.
- R3: Codes 0..3 rotate A: 0 left circular, 1 right circular, 2 left through carry, 3 right through carry. The rotated byte drives both `res_out` and `acc_out`. Copy-5 and copy-3 come from the result, H and N are cleared, C takes the bit shifted out, and S, Z and P/V keep their incoming values.
- R4: Codes 4..7 apply the same four rotates (in the same order) to the operand. `acc_out` equals the incoming A. S, Z, copy-5 and copy-3 follow the result, H=0, N=0, P/V is the parity of the result, and C is the bit shifted out.
- R5: Code 8 shifts left with a 0 into bit 0. Code 9 shifts right and keeps bit 7. Code 11 shifts right with a 0 into bit 7. The flags follow the rule of R4, and `acc_out` is unchanged.
- R6: Code 10 shifts left and forces bit 0 of the result to 1. C takes the old bit 7, and the other flags follow R4.
- R7: Code 12 (nibble rotate left) gives A' = {A[7:4], op[7:4]} and result {op[3:0], A[3:0]}. Code 13 (nibble rotate right) gives A' = {A[7:4], op[3:0]} and result {A[3:0], op[7:4]}. S, Z, copy-5, copy-3 and parity come from A', H=N=0, and C is kept.
- R8: Code 14 tests operand bit n. Z=1 when that bit is 0, P/V equals Z, H=1, N=0, C is kept, and copy-5/copy-3 are operand bits 5 and 3. `res_out` equals the operand and `acc_out` equals A.
- R9: In a bit test, S is 1 only when n=7 and operand bit 7 is 1.
- R10: Code 15 has no effect: `res_out` equals the operand, and `acc_out` and `flags_out` equal the incoming A and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (see R3..R10) |
| operand | input | 8 | Operand byte |
| acc_in | input | 8 | Current accumulator |
| bit_idx | input | 3 | Bit index for the bit test |
| flags_in | input | 8 | Incoming flag byte |
| res_out | output | 8 | Result byte |
| acc_out | output | 8 | Updated accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
The sweep goes through every operand value for every code. It varies A, the incoming flags and the bit index with it, so it reaches the carry-in paths and every flag bit. A design that recomputed S, Z or parity for the fast accumulator rotates would differ whenever the incoming flags disagree with the result. A design that treated code 10 as a plain left shift would produce even results. A bit test that set S for any set bit 7 would fail at n below 7. A nibble rotate that disturbed the carry or A's high nibble would differ on most vectors.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int HW = DW / 2;

  // Flag bit positions
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_Y  = 5;
  localparam int FB_H  = 4;
  localparam int FB_X  = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  typedef enum logic [3:0] {
    OP_ACC_RLC = 4'd0,
    OP_ACC_RRC = 4'd1,
    OP_ACC_RL  = 4'd2,
    OP_ACC_RR  = 4'd3,
    OP_RLC     = 4'd4,
    OP_RRC     = 4'd5,
    OP_RL      = 4'd6,
    OP_RR      = 4'd7,
    OP_SHL     = 4'd8,
    OP_ASR     = 4'd9,
    OP_SHL1    = 4'd10,
    OP_LSR     = 4'd11,
    OP_NIB_L   = 4'd12,
    OP_NIB_R   = 4'd13,
    OP_BTEST   = 4'd14,
    OP_NONE    = 4'd15
  } rsb_op_e;
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
(
  input  logic [2:0]    kind,
  input  logic [DW-1:0] din,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  // kind: low three bits of the opcode for codes 4..11 (and 0..3 using 4..7 forms)
  always_comb begin
    case (kind)
      3'd4: begin dout = {din[DW-2:0], din[DW-1]}; cout = din[DW-1]; end
      3'd5: begin dout = {din[0], din[DW-1:1]};    cout = din[0];    end
      3'd6: begin dout = {din[DW-2:0], cin};       cout = din[DW-1]; end
      3'd7: begin dout = {cin, din[DW-1:1]};       cout = din[0];    end
      3'd0: begin dout = {din[DW-2:0], 1'b0};      cout = din[DW-1]; end
      3'd1: begin dout = {din[DW-1], din[DW-1:1]}; cout = din[0];    end
      3'd2: begin dout = {din[DW-2:0], 1'b1};      cout = din[DW-1]; end
      default: begin dout = {1'b0, din[DW-1:1]};   cout = din[0];    end
    endcase
  end
endmodule

// File: rtl/rsb_nibble.sv
module rsb_nibble
  import rsb_pkg::*;
(
  input  logic          to_right,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem,
  output logic [DW-1:0] acc_n,
  output logic [DW-1:0] mem_n
);
  always_comb begin
    if (to_right) begin
      acc_n = {acc[DW-1:HW], mem[HW-1:0]};
      mem_n = {acc[HW-1:0], mem[DW-1:HW]};
    end else begin
      acc_n = {acc[DW-1:HW], mem[DW-1:HW]};
      mem_n = {mem[HW-1:0], acc[HW-1:0]};
    end
  end
endmodule

// File: rtl/rsb_bitcheck.sv
module rsb_bitcheck
  import rsb_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic [IW-1:0] idx,
  output logic          zero,
  output logic          sign
);
  assign zero = ~data[idx];
  assign sign = (idx == IW'(DW-1)) & data[DW-1];
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] acc_in,
  input  logic [IW-1:0] bit_idx,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] res_out,
  output logic [DW-1:0] acc_out,
  output logic [DW-1:0] flags_out
);
  rsb_op_e op;
  assign op = rsb_op_e'(op_sel);

  logic          is_acc_rot;
  logic [DW-1:0] sh_in, sh_out, nb_acc, nb_mem;
  logic          sh_c, bt_z, bt_s;
  logic [DW-1:0] res_n, acc_n, flg_n;

  assign is_acc_rot = (op_sel[3:2] == 2'b00);
  assign sh_in      = is_acc_rot ? acc_in : operand;

  rsb_shift u_shift (
    .kind (is_acc_rot ? {1'b1, op_sel[1:0]} : op_sel[2:0]),
    .din  (sh_in),
    .cin  (flags_in[FB_C]),
    .dout (sh_out),
    .cout (sh_c)
  );

  rsb_nibble u_nib (
    .to_right (op_sel[0]),
    .acc      (acc_in),
    .mem      (operand),
    .acc_n    (nb_acc),
    .mem_n    (nb_mem)
  );

  rsb_bitcheck u_bit (
    .data (operand),
    .idx  (bit_idx),
    .zero (bt_z),
    .sign (bt_s)
  );

  function automatic logic [DW-1:0] full_flags(input logic [DW-1:0] v, input logic c);
    logic [DW-1:0] f;
    f        = '0;
    f[FB_S]  = v[DW-1];
    f[FB_Z]  = (v == '0);
    f[FB_Y]  = v[5];
    f[FB_X]  = v[3];
    f[FB_PV] = ~^v;
    f[FB_C]  = c;
    return f;
  endfunction

  always_comb begin
    res_n = operand;
    acc_n = acc_in;
    flg_n = flags_in;
    case (op)
      OP_ACC_RLC, OP_ACC_RRC, OP_ACC_RL, OP_ACC_RR: begin
        res_n        = sh_out;
        acc_n        = sh_out;
        flg_n[FB_Y]  = sh_out[5];
        flg_n[FB_X]  = sh_out[3];
        flg_n[FB_H]  = 1'b0;
        flg_n[FB_N]  = 1'b0;
        flg_n[FB_C]  = sh_c;
      end
      OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SHL, OP_ASR, OP_SHL1, OP_LSR: begin
        res_n = sh_out;
        flg_n = full_flags(sh_out, sh_c);
      end
      OP_NIB_L, OP_NIB_R: begin
        res_n = nb_mem;
        acc_n = nb_acc;
        flg_n = full_flags(nb_acc, flags_in[FB_C]);
      end
      OP_BTEST: begin
        flg_n        = '0;
        flg_n[FB_S]  = bt_s;
        flg_n[FB_Z]  = bt_z;
        flg_n[FB_Y]  = operand[5];
        flg_n[FB_H]  = 1'b1;
        flg_n[FB_X]  = operand[3];
        flg_n[FB_PV] = bt_z;
        flg_n[FB_C]  = flags_in[FB_C];
      end
      default: ;
    endcase
  end

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      acc_out   <= '0;
      flags_out <= '0;
      seen      <= 1'b0;
    end else begin
      res_out   <= res_n;
      acc_out   <= acc_n;
      flags_out <= flg_n;
      seen      <= 1'b1;
    end
  end

  // R3: fast accumulator rotates leave S, Z, P/V as they came in
  a_r3_acc_rot_keeps_szp: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel[3:2]) == 2'b00) |->
      (flags_out[FB_S] == $past(flags_in[FB_S]) && flags_out[FB_Z] == $past(flags_in[FB_Z])
       && flags_out[FB_PV] == $past(flags_in[FB_PV])));

  // R4: operand rotates and shifts never disturb A
  a_r4_acc_untouched: assert property (@(posedge clk) disable iff (rst)
    (seen && ($past(op_sel[3:2]) == 2'b01 || $past(op_sel[3:2]) == 2'b10)) |->
      (acc_out == $past(acc_in)));

  // R5: arithmetic right shift keeps the sign bit
  a_r5_asr_keeps_msb: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel) == 4'd9) |-> (res_out[DW-1] == $past(operand[DW-1])));

  // R6: the one-filling left shift sets bit 0 and carries out old bit 7
  a_r6_shl1_sets_bit0: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel) == 4'd10) |->
      (res_out[0] && flags_out[FB_C] == $past(operand[DW-1])));

  // R7: nibble rotates keep C and A's high nibble
  a_r7_nibble_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel[3:1]) == 3'b110) |->
      (flags_out[FB_C] == $past(flags_in[FB_C]) && acc_out[DW-1:HW] == $past(acc_in[DW-1:HW])));

  // R8: bit test: P/V tracks Z, H set, N clear
  a_r8_bit_pv_tracks_z: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel) == 4'd14) |->
      (flags_out[FB_PV] == flags_out[FB_Z] && flags_out[FB_H] && !flags_out[FB_N]));

  // R9: sign only when testing the top bit
  a_r9_bit_sign_rule: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel) == 4'd14 && $past(bit_idx) != IW'(DW-1)) |-> !flags_out[FB_S]);

  // R10: no-op code leaves A and flags alone
  a_r10_none_passes: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(op_sel) == 4'd15) |->
      (acc_out == $past(acc_in) && flags_out == $past(flags_in) && res_out == $past(operand)));
endmodule

// File: tb/sim_rsb_unit.sv
`timescale 1ns/1ps
module sim_rsb_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op_sel;
  logic [7:0] operand, acc_in, flags_in;
  logic [2:0] bit_idx;
  logic [7:0] res_out, acc_out, flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rsb_unit u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .operand(operand), .acc_in(acc_in),
    .bit_idx(bit_idx), .flags_in(flags_in), .res_out(res_out), .acc_out(acc_out),
    .flags_out(flags_out)
  );

  function automatic string req_of(input int op);
    if (op < 4) return "R3";
    if (op < 8) return "R4";
    if (op == 10) return "R6";
    if (op < 12) return "R5";
    if (op < 14) return "R7";
    if (op == 14) return "R8";
    return "R10";
  endfunction

  // flags from a full result: S, Z, copy bits, even parity (R2 layout)
  function automatic int fullf(input int r, input int c);
    return (r & 'hA8) | ((r == 0) ? 'h40 : 0) | (($countones(8'(r)) % 2 == 0) ? 4 : 0) | c;
  endfunction

  task automatic model(input int op, input int v, input int a, input int f, input int n,
                       output logic [7:0] er, output logic [7:0] ea, output logic [7:0] ef);
    int r, c, na, z, ci;
    ci = f & 1;
    er = 8'(v); ea = 8'(a); ef = 8'(f);
    case (op)
      0: begin r = ((a << 1) | (a >> 7)) & 255; c = a >> 7; end
      1: begin r = (a >> 1) | ((a & 1) << 7); c = a & 1; end
      2: begin r = ((a << 1) & 255) | ci; c = a >> 7; end
      3: begin r = (a >> 1) | (ci << 7); c = a & 1; end
      4: begin r = ((v << 1) | (v >> 7)) & 255; c = v >> 7; end
      5: begin r = (v >> 1) | ((v & 1) << 7); c = v & 1; end
      6: begin r = ((v << 1) & 255) | ci; c = v >> 7; end
      7: begin r = (v >> 1) | (ci << 7); c = v & 1; end
      8: begin r = (v << 1) & 255; c = v >> 7; end
      9: begin r = (v >> 1) | (v & 128); c = v & 1; end
      10: begin r = ((v << 1) & 255) | 1; c = v >> 7; end
      11: begin r = v >> 1; c = v & 1; end
      default: begin r = 0; c = 0; end
    endcase
    if (op < 4) begin
      er = 8'(r); ea = 8'(r);
      ef = 8'((f & 'hC4) | (r & 'h28) | c);
    end else if (op < 12) begin
      er = 8'(r);
      ef = 8'(fullf(r, c));
    end else if (op == 12) begin
      na = (a & 'hF0) | (v >> 4);
      er = 8'(((v << 4) & 255) | (a & 15)); ea = 8'(na); ef = 8'(fullf(na, ci));
    end else if (op == 13) begin
      na = (a & 'hF0) | (v & 15);
      er = 8'(((a & 15) << 4) | (v >> 4)); ea = 8'(na); ef = 8'(fullf(na, ci));
    end else if (op == 14) begin
      z  = (((v >> n) & 1) == 0) ? 1 : 0;
      ef = 8'(((n == 7 && v >= 128) ? 128 : 0) | (z ? 'h44 : 0) | (v & 'h28) | 'h10 | ci);
    end
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; op_sel = 4'd15; operand = 8'hFF; acc_in = 8'hFF; flags_in = 8'hFF; bit_idx = 3'd7;
    repeat (3) @(negedge clk);
    // R1: reset clears every output
    chk("R1", "reset res", res_out, 8'h00);
    chk("R1", "reset acc", acc_out, 8'h00);
    chk("R1", "reset flags", flags_out, 8'h00);
    rst = 1'b0;
    // R1: one-cycle latency; value appears after the next edge only
    op_sel = 4'd15; operand = 8'h5A; acc_in = 8'h3C; flags_in = 8'h81;
    chk("R1", "no change before edge", res_out, 8'h00);
    @(negedge clk);
    chk("R1", "latency res", res_out, 8'h5A);
    // R2: bit test sets half-carry at bit 4, clears subtract at bit 1
    op_sel = 4'd14; operand = 8'h00; bit_idx = 3'd2; flags_in = 8'h02;
    @(negedge clk);
    chk("R2", "H at bit 4", flags_out & 8'h10, 8'h10);
    chk("R2", "N at bit 1", flags_out & 8'h02, 8'h00);
    chk("R2", "Z and P/V at bits 6,2", flags_out & 8'h44, 8'h44);
    // Sweep every code and operand with varied A, flags, index
    for (int op = 0; op < 16; op++) begin
      for (int v = 0; v < 256; v++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] er, ea, ef;
          int a, f, n;
          a = (v * 37 + k * 91 + op * 13) & 255;
          f = (v * 53 + k * 71 + 5) & 255;
          n = (v + k * 3) & 7;
          op_sel = 4'(op); operand = 8'(v); acc_in = 8'(a); flags_in = 8'(f); bit_idx = 3'(n);
          model(op, v, a, f, n, er, ea, ef);
          @(negedge clk);
          chk(req_of(op), "result", res_out, er);
          chk(req_of(op), "acc", acc_out, ea);
          chk(req_of(op), "flags", flags_out, ef);
          // R9: sign in bit test only for n=7 with bit 7 set
          if (op == 14) chk("R9", "bit sign", flags_out & 8'h80, (n == 7 && v >= 128) ? 8'h80 : 8'h00);
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule